// File: doc/BRIEF.md
# Mode-Filtered Performance Counter Bank

This block holds a small set of event counters for a processor core. Each counter has its own control register. The control register picks one event line out of a bus of single-cycle event pulses. It also picks the privilege levels during which that event is counted and an optional thread restriction. Software reads and writes every register through a single-cycle register port. Reads are combinational and writes take effect at the clock edge.

Software finds the bank in two steps. It first reads a configuration word whose bit 4 reports that counters exist. It then reads each control register in turn and keeps going while the top bit says another pair follows. To sample every N events, software writes 0x80000000 minus N into a counter and sets the interrupt-enable bit. The interrupt line then stays high while that counter's top bit is set. Rewriting the counter or clearing the enable bit drops the line.

Top module: `perf_counter_bank`

## Requirements
- R1: A synchronous active-low reset clears every control field and every counter to zero and deasserts `irq`. The read-only chain flags are not affected by reset.
- R2: Address 8 reads 0x00000010, with bit 4 set to flag that counters are present. Writes to address 8 have no effect.
- R3: Pair i uses address 2i for its control register and 2i+1 for its counter. Bit 31 of control register i reads 1 exactly when i < NUM_PAIRS-1. Writes to bit 31 are ignored.
- R4: Control bits 25:0 are writable and read back as written. Bits 30:26 always read 0. The layout is: bit 0 exception level, bit 1 kernel, bit 2 supervisor, bit 3 user, bit 4 interrupt enable, bits 15:5 event select, bits 19:16 group ID, bits 21:20 thread filter, bits 25:22 context ID.
- R5: A counter adds one in the cycle after its selected event pulses, provided the current level is enabled. When `exc_level` is 1, only bit 0 decides. Otherwise `priv_mode` decides: 0 means user (bit 3), 1 means supervisor (bit 2), 2 means kernel (bit 1), and 3 never counts.
- R6: Event select value s picks `events[s]`. Any value s >= NUM_EVENTS never counts.
- R7: Thread filter 0 counts for all threads. Filter 1 counts only when `group_id` equals bits 19:16. Filter 2 counts only when `context_id` equals bits 25:22. Filter 3 never counts.
- R8: A counter write in the same cycle as a counted event stores the written value, and the increment is lost.
- R9: Counters wrap from 0xFFFFFFFF to 0 and keep counting.
- R10: `irq` is high exactly while some counter has both its bit 31 and its control bit 4 set.
- R11: Addresses 9 to 15, and pair addresses at or beyond NUM_PAIRS, read 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| events | input | NUM_EVENTS | One-cycle event pulses |
| exc_level | input | 1 | Core is at exception level |
| priv_mode | input | 2 | 0 user, 1 supervisor, 2 kernel, 3 reserved |
| group_id | input | 4 | Running thread group ID |
| context_id | input | 4 | Running thread context ID |
| irq | output | 1 | Level overflow interrupt |

## Verification
Several checks run on every clock cycle inside the RTL. A counter may only take the written value, advance by one, or hold, and which of the three it does must agree with the write strobe and the filter verdict. The configuration word, the chain flags and the unmapped reads are also checked each cycle. The bench's scenarios cover the rest. They show that each filter field selects the right cycles, that each privilege level is honoured, and that out-of-range event selects never count. They also show wrap-around and the rise and fall of `irq` as software rewrites a counter or clears its enable bit. A cycle-level reference model in the bench checks random control words, modes, thread IDs and counter preloads near both overflow points.

// File: rtl/pcb_pkg.sv
// Package: shared constants and types for the performance counter bank.
// Assumes a 4-bit register address and 32-bit registers.
package pcb_pkg;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int CTRL_BITS  = 26;             // writable control bits 25:0
    localparam int SEL_LO     = 5;
    localparam int SEL_HI     = 15;
    localparam int GRP_LO     = 16;
    localparam int GRP_HI     = 19;
    localparam int FLT_LO     = 20;
    localparam int FLT_HI     = 21;
    localparam int CTX_LO     = 22;
    localparam int CTX_HI     = 25;
    localparam int IE_BIT     = 4;
    localparam logic [ADDR_W-1:0] CFG_ADDR = 4'd8;
    localparam logic [REG_W-1:0]  CFG_WORD = 32'h0000_0010;

    typedef enum logic [1:0] {
        MODE_USER   = 2'd0,
        MODE_SUPER  = 2'd1,
        MODE_KERNEL = 2'd2,
        MODE_RSVD   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        FLT_ALL   = 2'd0,
        FLT_GROUP = 2'd1,
        FLT_CTX   = 2'd2,
        FLT_NONE  = 2'd3
    } thr_flt_e;
endpackage

// File: rtl/pcb_filter.sv
// Module: pcb_filter
// Combinational verdict on whether one counter advances this cycle.
// Combines the privilege gate, the thread gate and the selected event line.
// Assumes the control word is already registered by the caller.
module pcb_filter
    import pcb_pkg::*;
#(
    parameter int NUM_EVENTS = 16
) (
    input  logic [CTRL_BITS-1:0]  cfg,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  exc_level,
    input  logic [1:0]            priv_mode,
    input  logic [3:0]            group_id,
    input  logic [3:0]            context_id,
    output logic                  count_en
);
    logic                  priv_ok;
    logic                  thr_ok;
    logic [NUM_EVENTS-1:0] shifted;

    // Privilege gate: exception level overrides the mode decode.
    always_comb begin
        unique case (priv_e'(priv_mode))
            MODE_USER:   priv_ok = cfg[3];
            MODE_SUPER:  priv_ok = cfg[2];
            MODE_KERNEL: priv_ok = cfg[1];
            default:     priv_ok = 1'b0;
        endcase
        if (exc_level) priv_ok = cfg[0];
    end

    // Thread gate: selects which ID field, if any, must match.
    always_comb begin
        unique case (thr_flt_e'(cfg[FLT_HI:FLT_LO]))
            FLT_ALL:   thr_ok = 1'b1;
            FLT_GROUP: thr_ok = (cfg[GRP_HI:GRP_LO] == group_id);
            FLT_CTX:   thr_ok = (cfg[CTX_HI:CTX_LO] == context_id);
            default:   thr_ok = 1'b0;
        endcase
    end

    // Event pick: shifting past the bus width yields zero, so large selects never count.
    always_comb begin
        shifted  = events >> cfg[SEL_HI:SEL_LO];
        count_en = priv_ok & thr_ok & shifted[0];
    end
endmodule

// File: rtl/pcb_pair.sv
// Module: pcb_pair
// One control register and one 32-bit event counter, plus the overflow flag.
// A counter write beats a same-cycle increment. The chain flag is fixed by HAS_NEXT.
module pcb_pair
    import pcb_pkg::*;
#(
    parameter int NUM_EVENTS = 16,
    parameter bit HAS_NEXT   = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_we,
    input  logic                  cnt_we,
    input  logic [REG_W-1:0]      wdata,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  exc_level,
    input  logic [1:0]            priv_mode,
    input  logic [3:0]            group_id,
    input  logic [3:0]            context_id,
    output logic [REG_W-1:0]      ctrl_rd,
    output logic [REG_W-1:0]      cnt_rd,
    output logic                  ovf
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [REG_W-1:0]     cnt_q;
    logic                 count_en;

    pcb_filter #(.NUM_EVENTS(NUM_EVENTS)) u_filter (
        .cfg        (ctrl_q),
        .events     (events),
        .exc_level  (exc_level),
        .priv_mode  (priv_mode),
        .group_id   (group_id),
        .context_id (context_id),
        .count_en   (count_en)
    );

    // Control register: only the writable low bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata[CTRL_BITS-1:0];
    end

    // Counter: a write takes priority, otherwise add one on a filtered event.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_we)   cnt_q <= wdata;
        else if (count_en) cnt_q <= cnt_q + 1'b1;
    end

    // Read views and overflow flag.
    always_comb begin
        ctrl_rd = {HAS_NEXT, 5'b0, ctrl_q};
        cnt_rd  = cnt_q;
        ovf     = ctrl_q[IE_BIT] & cnt_q[REG_W-1];
    end

    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> cnt_rd == $past(wdata));
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && count_en) |=> cnt_rd == $past(cnt_rd) + 32'd1);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !count_en) |=> $stable(cnt_rd));
    p_ctrl_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ctrl_rd[CTRL_BITS-1:0] == $past(wdata[CTRL_BITS-1:0]));
endmodule

// File: rtl/perf_counter_bank.sv
// Module: perf_counter_bank (top)
// Bank of NUM_PAIRS (1..4) control/counter pairs behind a register port.
// Decodes addresses, muxes read data and ORs the overflow flags into one level irq.
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_PAIRS  = 4,
    parameter int NUM_EVENTS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [3:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  exc_level,
    input  logic [1:0]            priv_mode,
    input  logic [3:0]            group_id,
    input  logic [3:0]            context_id,
    output logic                  irq
);
    localparam int LAST = NUM_PAIRS - 1;

    logic [REG_W-1:0] ctrl_rd [NUM_PAIRS];
    logic [REG_W-1:0] cnt_rd  [NUM_PAIRS];
    logic [NUM_PAIRS-1:0] ovf;
    logic [NUM_PAIRS-1:0] hit;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        // Address hit for this pair, either register.
        assign hit[g] = !reg_addr[3] && (reg_addr[2:1] == 2'(g));

        pcb_pair #(
            .NUM_EVENTS (NUM_EVENTS),
            .HAS_NEXT   (g < LAST)
        ) u_pair (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (reg_wr && hit[g] && !reg_addr[0]),
            .cnt_we     (reg_wr && hit[g] &&  reg_addr[0]),
            .wdata      (reg_wdata),
            .events     (events),
            .exc_level  (exc_level),
            .priv_mode  (priv_mode),
            .group_id   (group_id),
            .context_id (context_id),
            .ctrl_rd    (ctrl_rd[g]),
            .cnt_rd     (cnt_rd[g]),
            .ovf        (ovf[g])
        );

        p_more_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && !reg_addr[0]) |-> reg_rdata[31] == (g < LAST));
    end

    // Read mux: configuration word, the addressed pair register, or zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CFG_ADDR) reg_rdata = CFG_WORD;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (hit[k]) reg_rdata = reg_addr[0] ? cnt_rd[k] : ctrl_rd[k];
        end
    end

    // Level interrupt while any enabled counter has its top bit set.
    always_comb irq = |ovf;

    p_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == CFG_ADDR) |-> reg_rdata == CFG_WORD);
    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > CFG_ADDR) |-> reg_rdata == 32'd0);
    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf == '0) |-> !irq);
endmodule

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NE = 16;

    logic clk = 0, rst_n = 0, reg_wr = 0, exc_level = 0, irq;
    logic [3:0] reg_addr = 0, group_id = 0, context_id = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic [NE-1:0] events = 0;
    logic [1:0] priv_mode = 0;

    int checks = 0, failures = 0;
    bit done = 0;
    bit [31:0] ctrl_m [NP];
    bit [31:0] cnt_m  [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_counter_bank #(.NUM_PAIRS(NP), .NUM_EVENTS(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events),
        .exc_level(exc_level), .priv_mode(priv_mode), .group_id(group_id),
        .context_id(context_id), .irq(irq));

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Counting rule from R5, R6, R7.
    function automatic bit elig(bit [31:0] c);
        bit p, t;
        case (priv_mode)
            2'd0: p = c[3];
            2'd1: p = c[2];
            2'd2: p = c[1];
            default: p = 0;
        endcase
        if (exc_level) p = c[0];
        case (c[21:20])
            2'd0: t = 1;
            2'd1: t = (c[19:16] == group_id);
            2'd2: t = (c[25:22] == context_id);
            default: t = 0;
        endcase
        return p && t && (c[15:5] < NE) && events[c[15:5]];
    endfunction

    // Read map from R2, R3, R4, R11.
    function automatic bit [31:0] mread(bit [3:0] a);
        if (a == 4'd8) return 32'h10;
        if (a < 4'd8 && int'(a >> 1) < NP) begin
            if (a[0]) return cnt_m[a >> 1];
            return ctrl_m[a >> 1] | ((int'(a >> 1) < NP - 1) ? 32'h8000_0000 : 32'h0);
        end
        return 0;
    endfunction

    function automatic bit mirq();
        bit r = 0;
        for (int i = 0; i < NP; i++) r |= ctrl_m[i][4] & cnt_m[i][31];
        return r;
    endfunction

    // One cycle: compare against the model, then advance it at the edge.
    task automatic step();
        string tag;
        #1;
        if (reg_addr == 4'd8) tag = "R2";
        else if (reg_addr > 4'd8) tag = "R11";
        else if (reg_addr[0]) tag = "R5";
        else tag = "R4";
        chk(tag, reg_rdata, mread(reg_addr));
        chk("R10", {31'b0, irq}, {31'b0, mirq()});
        @(posedge clk);
        for (int i = 0; i < NP; i++) if (elig(ctrl_m[i])) cnt_m[i]++;
        if (reg_wr && !reg_addr[3] && int'(reg_addr >> 1) < NP) begin
            if (reg_addr[0]) cnt_m[reg_addr >> 1] = reg_wdata;
            else ctrl_m[reg_addr >> 1] = reg_wdata & 32'h03FF_FFFF;
        end
        @(negedge clk);
    endtask

    task automatic wr(bit [3:0] a, bit [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; events = 0;
        step();
        reg_wr = 0;
    endtask

    task automatic peek(bit [3:0] a, string tag, bit [31:0] exp);
        reg_wr = 0; reg_addr = a; events = 0;
        #1 chk(tag, reg_rdata, exp);
        step();
    endtask

    task automatic pulse(bit [NE-1:0] e, bit [1:0] m, bit x, bit [3:0] g, bit [3:0] t);
        events = e; priv_mode = m; exc_level = x; group_id = g; context_id = t;
        step();
        events = 0; exc_level = 0; priv_mode = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NP; i++) begin ctrl_m[i] = 0; cnt_m[i] = 0; end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state, R2 config, R3 chain flags, R11 unmapped
        #1 chk("R1", {31'b0, irq}, 0);
        peek(0, "R1", 32'h8000_0000);
        peek(1, "R1", 0);
        peek(6, "R3", 0);
        peek(8, "R2", 32'h10);
        peek(9, "R11", 0);
        wr(6, 32'hFFFF_FFFF); peek(6, "R3", 32'h03FF_FFFF);
        wr(0, 32'hFFFF_FFFF); peek(0, "R4", 32'h83FF_FFFF);
        wr(8, 32'h0); peek(8, "R2", 32'h10);
        wr(6, 0);

        // R5 privilege gating
        wr(0, 32'h8); wr(1, 0);
        pulse(1, 0, 0, 0, 0); peek(1, "R5", 1);
        pulse(1, 2, 0, 0, 0); peek(1, "R5", 1);
        pulse(1, 0, 1, 0, 0); peek(1, "R5", 1);
        wr(0, 32'h1);
        pulse(1, 2, 1, 0, 0); peek(1, "R5", 2);
        wr(0, 32'h6);
        pulse(1, 3, 0, 0, 0); peek(1, "R5", 2);

        // R6 event select
        wr(0, (32'd20 << 5) | 32'h8);
        pulse('1, 0, 0, 0, 0); peek(1, "R6", 2);
        wr(0, (32'd3 << 5) | 32'h8);
        pulse(16'h0008, 0, 0, 0, 0); peek(1, "R6", 3);
        pulse(16'hFFF7, 0, 0, 0, 0); peek(1, "R6", 3);

        // R7 thread filter
        wr(0, 32'h8 | (32'd1 << 20) | (32'd5 << 16));
        pulse(1, 0, 0, 5, 0); peek(1, "R7", 4);
        pulse(1, 0, 0, 6, 0); peek(1, "R7", 4);
        wr(0, 32'h8 | (32'd2 << 20) | (32'd9 << 22));
        pulse(1, 0, 0, 0, 9); peek(1, "R7", 5);
        pulse(1, 0, 0, 0, 2); peek(1, "R7", 5);
        wr(0, 32'h8 | (32'd3 << 20));
        pulse(1, 0, 0, 0, 0); peek(1, "R7", 5);

        // R8 write beats a same-cycle event
        wr(0, 32'h8);
        reg_wr = 1; reg_addr = 1; reg_wdata = 100; events = 1;
        step();
        reg_wr = 0; events = 0;
        peek(1, "R8", 100);

        // R9 wrap and continue
        wr(1, 32'hFFFF_FFFF);
        pulse(1, 0, 0, 0, 0); peek(1, "R9", 0);
        pulse(1, 0, 0, 0, 0); peek(1, "R9", 1);

        // R10 level interrupt
        wr(0, 32'h18); wr(1, 32'h7FFF_FFFF);
        #1 chk("R10", {31'b0, irq}, 0);
        pulse(1, 0, 0, 0, 0);
        #1 chk("R10", {31'b0, irq}, 1);
        step();
        #1 chk("R10", {31'b0, irq}, 1);
        wr(1, 0);
        #1 chk("R10", {31'b0, irq}, 0);
        wr(1, 32'h8000_0000);
        #1 chk("R10", {31'b0, irq}, 1);
        wr(0, 32'h8);
        #1 chk("R10", {31'b0, irq}, 0);

        // R11 unmapped write ignored
        wr(12, 32'h1234); peek(12, "R11", 0);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            events = NE'($urandom);
            priv_mode = 2'($urandom);
            exc_level = ($urandom % 8) == 0;
            group_id = 4'($urandom % 4);
            context_id = 4'($urandom % 4);
            reg_addr = 4'($urandom);
            reg_wr = ($urandom % 8) == 0;
            r = $urandom % 4;
            if (reg_addr[0]) begin
                case (r)
                    0: reg_wdata = $urandom;
                    1: reg_wdata = 32'h7FFF_FFF0 + ($urandom % 16);
                    2: reg_wdata = 32'hFFFF_FFF0 + ($urandom % 16);
                    default: reg_wdata = $urandom % 64;
                endcase
            end else if (r == 0) begin
                reg_wdata = $urandom;
            end else begin
                reg_wdata = ($urandom % 32) | (($urandom % 20) << 5) |
                            (($urandom % 4) << 16) | (($urandom % 4) << 20) |
                            (($urandom % 4) << 22);
            end
            step();
        end
        reg_wr = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule